// File: doc/BRIEF.md
# NAND Flash Read-Path Device Model

This block is a synthesizable stand-in for a small read-only NAND-style flash device. A controller reaches it over an 8-bit byte bus shared between commands, address bytes and data, framed by an active-low chip enable, a command-latch line, an address-latch line and separate active-low write and read strobes. A command chooses one of three read modes. Each mode fixes the starting column inside a 528-byte page. Three address bytes then build a byte pointer, and every read strobe returns the byte at the pointer and moves the pointer on by one.

The storage is a fixed image computed from the pointer, so no memory array is built. In erased mode every byte reads 0xFF. A pattern mode returns a value derived from the address, so that pointer arithmetic can be seen at the pins. The pointer wraps at a power-of-two depth, which lets a small depth stand in for a full device. The device never reports busy.

The bus is split into `din` and `dout` with an output enable, and the pad driver outside the block uses that enable. Strobe events are falling edges of the strobes, sampled on `clk`.

Top module: `nfr_read_model`

## Requirements
- R1: While `rst_n` is low, `rdy`, `dout_oe` and `err` are 0 and `dout` is 0x00. After reset the pointer is 0 and the device is idle, with no read mode selected.
- R2: The command bytes are: 0xFF returns to idle. 0x00 selects column offset 0. 0x01 selects column offset 0x100. 0x50 selects column offset 0x200. Each read command restarts the address-byte count.
- R3: A command byte is taken on a falling edge of `we_n` with `cle` high. An address byte is taken on a falling edge of `we_n` with `ale` high and `cle` low.
- R4: The address bytes a0, a1 and a2 set the pointer to ((a0 OR offset) + a1×135168 + a2×528) modulo DEPTH. a1 is weighted by 528×256 and a2 by 528.
- R5: A falling edge of `re_n` while `cle`, `ale` and `we_n` are low, low and high loads `dout` with the byte at the pointer one clock later and then adds one to the pointer. At all other times `dout` holds its value.
- R6: With FILL_MODE 0 every byte reads 0xFF. With FILL_MODE 1 the byte at pointer p is the bitwise NOT of the XOR of the 8-bit slices of p (bits 7:0, 15:8, 23:16, 31:24).
- R7: `dout_oe` is 1 in the clock after `ce_n` and `re_n` are both sampled low. Otherwise it is 0, so the bus is released when both strobes are high.
- R8: After reset `rdy` is 1 in every cycle.
- R9: An address byte taken while idle, or a fourth address byte, leaves the pointer unchanged and sets `err`.
- R10: An unknown command byte leaves the mode and the address-byte count unchanged and sets `err`. `err` stays set until reset.
- R11: While `ce_n` is high every strobe is ignored: no command, address or read takes effect, and `dout_oe` stays 0.
- R12: The pointer wraps modulo DEPTH, both when the address bytes are summed and when reads increment it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| din | input | 8 | Byte bus into the device |
| dout | output | 8 | Byte bus out of the device |
| dout_oe | output | 1 | Drive enable for `dout` |
| rdy | output | 1 | Ready flag, high after reset |
| err | output | 1 | Sticky protocol error flag |

## Verification
A wrong mode or a miscounted address byte shows up at the first read after the third address byte, as a wrong byte one clock after the read strobe falls. The pattern image makes every pointer value read back as a distinct byte. A pointer that steps wrongly or fails to wrap shows up on the second read of a run. Ignored strobes (deselected, out of mode, unknown command) are judged by the next selected read and by `err`, which must change in the clock after the offending strobe edge and not before.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_COL0 = 2'd1,
      MODE_COL1 = 2'd2,
      MODE_COL2 = 2'd3
   } nfr_mode_t;

   localparam logic [7:0] OP_IDLE = 8'hFF;
   localparam logic [7:0] OP_COL0 = 8'h00;
   localparam logic [7:0] OP_COL1 = 8'h01;
   localparam logic [7:0] OP_COL2 = 8'h50;

   localparam int unsigned PAGE_BYTES = 528;
   localparam int unsigned BLOCK_STRIDE = PAGE_BYTES * 256;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;

   // column offset ORed into the first address byte
   function automatic logic [31:0] col_offset(input nfr_mode_t m);
      case (m)
         MODE_COL1: return 32'h100;
         MODE_COL2: return 32'h200;
         default:   return 32'h000;
      endcase
   endfunction

   // XOR of all byte slices of a pointer
   function automatic logic [7:0] fold_bytes(input logic [31:0] p);
      logic [7:0] r;
      r = '0;
      for (int i = 0; i < 4; i++) r ^= p[8*i +: 8];
      return r;
   endfunction

endpackage

// File: rtl/nfr_cmd_decode.sv
module nfr_cmd_decode
   import nfr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_stb,
   input  logic       addr_stb,
   input  logic [7:0] din,
   output nfr_mode_t  mode,
   output logic       addr_take,
   output logic [1:0] addr_idx,
   output logic       bad_cmd,
   output logic       bad_addr
);

   localparam logic [1:0] LAST_IDX = 2'd2;

   nfr_mode_t  mode_q, mode_d;
   logic [1:0] cnt_q, cnt_d;
   logic       known;

   always_comb begin
      mode_d = mode_q;
      cnt_d  = cnt_q;
      known  = 1'b1;
      if (cmd_stb) begin
         case (din)
            OP_IDLE: begin mode_d = MODE_IDLE; cnt_d = '0; end
            OP_COL0: begin mode_d = MODE_COL0; cnt_d = '0; end
            OP_COL1: begin mode_d = MODE_COL1; cnt_d = '0; end
            OP_COL2: begin mode_d = MODE_COL2; cnt_d = '0; end
            default: known = 1'b0;
         endcase
      end else if (addr_take) begin
         cnt_d = cnt_q + 2'd1;
      end
   end

   assign addr_take = addr_stb && (mode_q != MODE_IDLE) && (cnt_q <= LAST_IDX);
   assign addr_idx  = cnt_q;
   assign bad_addr  = addr_stb && !addr_take;
   assign bad_cmd   = cmd_stb && !known;
   assign mode      = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_IDLE;
         cnt_q  <= '0;
      end else begin
         mode_q <= mode_d;
         cnt_q  <= cnt_d;
      end
   end

endmodule

// File: rtl/nfr_addr_ptr.sv
module nfr_addr_ptr
   import nfr_pkg::*;
#(
   parameter int unsigned PTR_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  nfr_mode_t        mode,
   input  logic             addr_take,
   input  logic [1:0]       addr_idx,
   input  logic [7:0]       din,
   input  logic             rd_stb,
   output logic [PTR_W-1:0] ptr
);

   logic [31:0] ptr_ext, sum;
   logic [PTR_W-1:0] ptr_d;

   assign ptr_ext = 32'(ptr);

   always_comb begin
      case (addr_idx)
         2'd0:    sum = col_offset(mode) | 32'(din);
         2'd1:    sum = ptr_ext + 32'(din) * 32'(BLOCK_STRIDE);
         2'd2:    sum = ptr_ext + 32'(din) * 32'(PAGE_BYTES);
         default: sum = ptr_ext;
      endcase
      if (addr_take)   ptr_d = sum[PTR_W-1:0];
      else if (rd_stb) ptr_d = ptr + 1'b1;
      else             ptr_d = ptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_d;
   end

endmodule

// File: rtl/nfr_image.sv
module nfr_image
   import nfr_pkg::*;
#(
   parameter int unsigned PTR_W     = 20,
   parameter int unsigned FILL_MODE = 0
) (
   input  logic [PTR_W-1:0] ptr,
   output logic [7:0]       rd_byte
);

   localparam logic [7:0] PAT_MASK = (FILL_MODE == 1) ? 8'hFF : 8'h00;

   assign rd_byte = ERASED_BYTE ^ (fold_bytes(32'(ptr)) & PAT_MASK);

endmodule

// File: rtl/nfr_read_model.sv
module nfr_read_model
   import nfr_pkg::*;
#(
   parameter int unsigned DEPTH     = 1 << 20,
   parameter int unsigned FILL_MODE = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       we_n,
   input  logic       re_n,
   input  logic [7:0] din,
   output logic [7:0] dout,
   output logic       dout_oe,
   output logic       rdy,
   output logic       err
);

   localparam int unsigned PTR_W = $clog2(DEPTH);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth_pow2
         $error("nfr_read_model: DEPTH must be a power of two");
      end
      if (DEPTH < 256 || DEPTH > (1 << 24)) begin : g_bad_depth_range
         $error("nfr_read_model: DEPTH out of range");
      end
      if (FILL_MODE > 1) begin : g_bad_fill
         $error("nfr_read_model: FILL_MODE must be 0 or 1");
      end
   endgenerate

   logic we_g, re_g, we_q, re_q;
   logic cmd_stb, addr_stb, rd_stb;
   logic addr_take, bad_cmd, bad_addr;
   logic [1:0] addr_idx;
   nfr_mode_t mode;
   logic [PTR_W-1:0] ptr;
   logic [7:0] rd_byte;

   // strobes count only while selected
   assign we_g = we_n | ce_n;
   assign re_g = re_n | ce_n;

   assign cmd_stb  = we_q && !we_g && cle;
   assign addr_stb = we_q && !we_g && ale && !cle;
   assign rd_stb   = re_q && !re_g && !cle && !ale && we_n;

   nfr_cmd_decode u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_stb   (cmd_stb),
      .addr_stb  (addr_stb),
      .din       (din),
      .mode      (mode),
      .addr_take (addr_take),
      .addr_idx  (addr_idx),
      .bad_cmd   (bad_cmd),
      .bad_addr  (bad_addr)
   );

   nfr_addr_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .addr_take (addr_take),
      .addr_idx  (addr_idx),
      .din       (din),
      .rd_stb    (rd_stb),
      .ptr       (ptr)
   );

   nfr_image #(.PTR_W(PTR_W), .FILL_MODE(FILL_MODE)) u_img (
      .ptr     (ptr),
      .rd_byte (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b1;
         re_q    <= 1'b1;
         dout    <= '0;
         dout_oe <= 1'b0;
         rdy     <= 1'b0;
         err     <= 1'b0;
      end else begin
         we_q    <= we_g;
         re_q    <= re_g;
         dout_oe <= !re_g;
         rdy     <= 1'b1;
         err     <= err | bad_cmd | bad_addr;
         if (rd_stb) dout <= rd_byte;
      end
   end

endmodule

// File: rtl/nfr_read_model_chk.sv
module nfr_read_model_chk #(
   parameter int unsigned PTR_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce_n,
   input logic             re_n,
   input logic [7:0]       dout,
   input logic             dout_oe,
   input logic             rdy,
   input logic             err,
   input logic             rd_stb,
   input logic [PTR_W-1:0] ptr
);

   AST_RDY_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> rdy); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R10

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (!dout_oe && $stable(dout) && $stable(ptr))); // R11

   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      re_n |=> !dout_oe); // R7

   AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> (ptr == PTR_W'($past(ptr) + 1'b1))); // R5

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(dout)); // R5

endmodule

bind nfr_read_model nfr_read_model_chk #(.PTR_W(PTR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_n    (ce_n),
   .re_n    (re_n),
   .dout    (dout),
   .dout_oe (dout_oe),
   .rdy     (rdy),
   .err     (err),
   .rd_stb  (rd_stb),
   .ptr     (ptr)
);

// File: tb/tb_nfr_read_model.sv
module tb_nfr_read_model;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
   logic [7:0] din = '0;

   logic [7:0] dout, dout_sm, dout_er;
   logic oe, oe_sm, oe_er, rdy, rdy_sm, rdy_er, err, err_sm, err_er;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   nfr_read_model #(.DEPTH(1 << 20), .FILL_MODE(1)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .din(din), .dout(dout), .dout_oe(oe), .rdy(rdy), .err(err));

   nfr_read_model #(.DEPTH(1024), .FILL_MODE(1)) dut_sm (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .din(din), .dout(dout_sm), .dout_oe(oe_sm), .rdy(rdy_sm), .err(err_sm));

   nfr_read_model #(.DEPTH(1024), .FILL_MODE(0)) dut_er (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .re_n(re_n), .din(din), .dout(dout_er), .dout_oe(oe_er), .rdy(rdy_er), .err(err_er));

   // {kind, byte, expected}: kind 0 command, 1 address, 2 read
   localparam int NV = 23;
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 8'h00, 8'h00}, {2'd1, 8'h12, 8'h00}, {2'd1, 8'h01, 8'h00}, {2'd1, 8'h02, 8'h00},
      {2'd2, 8'h00, 8'hDB}, {2'd2, 8'h00, 8'hDA}, {2'd2, 8'h00, 8'hDD},
      {2'd0, 8'h01, 8'h00}, {2'd1, 8'h05, 8'h00}, {2'd1, 8'h00, 8'h00}, {2'd1, 8'h00, 8'h00},
      {2'd2, 8'h00, 8'hFB}, {2'd2, 8'h00, 8'hF8},
      {2'd0, 8'h50, 8'h00}, {2'd1, 8'h80, 8'h00}, {2'd1, 8'h00, 8'h00}, {2'd1, 8'h03, 8'h00},
      {2'd2, 8'h00, 8'h47},
      {2'd0, 8'h50, 8'h00}, {2'd1, 8'hFF, 8'h00}, {2'd1, 8'h07, 8'h00}, {2'd1, 8'hC1, 8'h00},
      {2'd2, 8'h00, 8'hF1}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ce_n = 1'b0; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic is_cmd, input logic [7:0] b);
      @(negedge clk);
      cle = is_cmd; ale = !is_cmd; din = b; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] exp);
      @(negedge clk);
      re_n = 1'b0;
      @(negedge clk);
      check(req, dout, exp);
      check("R7 oe during read", {7'd0, oe}, 8'd1);
      check("R8 rdy", {7'd0, rdy}, 8'd1);
      re_n = 1'b1;
      @(negedge clk);
      check("R7 oe released", {7'd0, oe}, 8'd0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      check("R1 rdy in reset", {7'd0, rdy}, 8'd0);
      check("R1 oe in reset", {7'd0, oe}, 8'd0);
      check("R1 err in reset", {7'd0, err}, 8'd0);
      check("R1 dout in reset", dout, 8'h00);
      rst_n = 1'b1;

      // R2 R3 R4 R6 R12: mode, address weighting and pattern image
      for (int i = 0; i < NV; i++) begin
         case (VEC[i][17:16])
            2'd0: wr(1'b1, VEC[i][15:8]);
            2'd1: wr(1'b0, VEC[i][15:8]);
            default: rd($sformatf("R4 vector %0d", i), VEC[i][7:0]);
         endcase
      end
      check("R9 no error on legal traffic", {7'd0, err}, 8'd0);

      // R11: deselected strobes are ignored
      do_reset();
      ce_n = 1'b1;
      wr(1'b1, 8'h01); wr(1'b0, 8'h33); wr(1'b0, 8'h01); wr(1'b0, 8'h01);
      @(negedge clk); re_n = 1'b0;
      @(negedge clk);
      check("R11 oe deselected", {7'd0, oe}, 8'd0);
      check("R11 dout deselected", dout, 8'h00);
      re_n = 1'b1;
      @(negedge clk); ce_n = 1'b0;
      check("R11 no error", {7'd0, err}, 8'd0);
      rd("R11 pointer untouched", 8'hFF);
      rd("R5 pointer step", 8'hFE);

      // R9: address while idle
      do_reset();
      wr(1'b0, 8'h20);
      check("R9 idle address error", {7'd0, err}, 8'd1);
      rd("R9 idle address ignored", 8'hFF);

      // R9: fourth address byte
      do_reset();
      wr(1'b1, 8'h00); wr(1'b0, 8'h10); wr(1'b0, 8'h00); wr(1'b0, 8'h00);
      check("R9 clean before 4th byte", {7'd0, err}, 8'd0);
      wr(1'b0, 8'h55);
      check("R9 4th byte error", {7'd0, err}, 8'd1);
      rd("R9 4th byte ignored", 8'hEF);

      // R10: unknown command keeps mode and count
      do_reset();
      wr(1'b1, 8'h00); wr(1'b0, 8'h22);
      wr(1'b1, 8'h90);
      check("R10 unknown command error", {7'd0, err}, 8'd1);
      wr(1'b0, 8'h00); wr(1'b0, 8'h00);
      rd("R10 count kept", 8'hDD);
      check("R10 err sticky", {7'd0, err}, 8'd1);

      // R2: 0xFF returns to idle
      do_reset();
      wr(1'b1, 8'h01); wr(1'b1, 8'hFF);
      check("R2 idle no error yet", {7'd0, err}, 8'd0);
      wr(1'b0, 8'h05);
      check("R2 idle after FF", {7'd0, err}, 8'd1);

      // R12 R6: increment wrap on small depth, erased image
      do_reset();
      wr(1'b1, 8'h01); wr(1'b0, 8'hEF); wr(1'b0, 8'h00); wr(1'b0, 8'h01);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); re_n = 1'b0;
         @(negedge clk);
         check("R12 wrap read", dout_sm, (k == 0) ? 8'h03 : (k == 1) ? 8'hFF : 8'hFE);
         check("R6 erased byte", dout_er, 8'hFF);
         re_n = 1'b1;
      end
      @(negedge clk);
      check("R8 rdy small", {7'd0, rdy_sm & rdy_er}, 8'd1);
      check("R9 small no error", {7'd0, err_sm | err_er | oe_sm | oe_er}, 8'd0);

      finish_run();
   end

endmodule